// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This peripheral keeps a 32-bit unsigned count of elapsed seconds. A prescaler divides the input clock by `CLKS_PER_TICK` to make a one-cycle update pulse. The count advances on that pulse, and only while the run bit is set. Software can preload the count, but the preload lands on the next update pulse and not at once. Software can also program a match value. When the count reaches that value on an update, a sticky raw status bit is set, and the interrupt output follows it through separate enable and mask bits.

Access is through a single-cycle register bus. The read data is combinational in the cycle of the request. A write commits on the rising edge that ends the request. Reading the acknowledge register clears the pending event. Every access uses a word address. Bits [1:0] of the address must be zero; any other access is dropped and reads as zero.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low, except the identity register at 0x1C, which reads `VERSION`.
- R2: While control bit 2 (run) is set, the count at 0x00 rises by one exactly `CLKS_PER_TICK` cycles after the write that sets run, and again every `CLKS_PER_TICK` cycles after that. With run clear the count holds.
- R3: The preload register at 0x08 reads back the last value written to it. That value reaches the count at the next update pulse and not before it. It is not applied while run is clear.
- R4: When an update makes the count equal to the match register at 0x04, bit 0 of the raw status register at 0x14 is set. The bit stays set until it is acknowledged.
- R5: `irq_o` and bit 0 of the masked status register at 0x10 both equal raw AND control bit 0 (enable) AND NOT control bit 1 (mask).
- R6: A read of 0x18 clears the raw status bit, and with it `irq_o`, on the edge that ends the read.
- R7: With control bit 3 (wrap) set, the update after a match loads zero. With wrap clear, counting continues past the match, and it rolls over from 0xFFFFFFFF to 0.
- R8: Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C have no effect. Any access whose address bits [1:0] are not zero is ignored, and such a read returns 0.
- R9: The control register at 0x0C reads back bits [3:0] as written, with zeros above them. The match register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume that `req_i` is a clean strobe with a stable address and stable data during its cycle. They also assume that reset is held long enough to clear the prescaler. The bench drives every access on a falling edge and holds it for exactly one cycle. It samples the combinational read data shortly after driving, so each read sees the state from before the edge it commits on. Test sequences that count update pulses always start from a disabled counter, so the prescaler phase is known.

// File: rtl/rtc_seconds_pkg.sv
package rtc_seconds_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;
  localparam int unsigned SW = AW - 2;

  typedef enum logic [SW-1:0] {
    REG_COUNT = 3'd0,
    REG_MATCH = 3'd1,
    REG_LOAD  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_STAT  = 3'd4,
    REG_RAW   = 3'd5,
    REG_ACK   = 3'd6,
    REG_ID    = 3'd7
  } reg_sel_e;

  // field order sets bit positions: ie=0, mask=1, run=2, wrap=3
  typedef struct packed {
    logic wrap;
    logic run;
    logic mask;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned CLKS_PER_TICK = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(CLKS_PER_TICK);
      localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (!en_i)         div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign tick_o = en_i && (div_q == LAST);

      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

  p_tick_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> en_i);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_seconds_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wrap_i,
  input  logic          load_wr_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] match_i,
  input  logic          ack_i,
  output logic [DW-1:0] count_o,
  output logic          raw_o
);
  logic [DW-1:0] count_q, count_nxt;
  logic          pend_q, raw_q;

  always_comb begin
    if (pend_q)                             count_nxt = load_val_i;
    else if (wrap_i && (count_q == match_i)) count_nxt = '0;
    else                                    count_nxt = count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      pend_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (tick_i) count_q <= count_nxt;
      // a write in the same cycle as a pulse keeps the preload pending
      if (load_wr_i)   pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;
      if (tick_i && (count_nxt == match_i)) raw_q <= 1'b1;
      else if (ack_i)                       raw_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign raw_o   = raw_q;

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_q));
  p_preload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pend_q) |=> (count_q == $past(load_val_i)));
  p_raw_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && !ack_i) |=> raw_q);
  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i) |=> !raw_q);
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_seconds_pkg::*;
#(
  parameter logic [DW-1:0] VERSION = 32'h0001_0200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] count_i,
  input  logic          raw_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] match_o,
  output logic [DW-1:0] load_o,
  output logic          load_wr_o,
  output logic          ack_o,
  output logic          irq_o,
  output logic [DW-1:0] rdata_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] match_q, load_q;
  logic          aligned, wr_hit, rd_hit;
  reg_sel_e      sel;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr_i[AW-1:2]);
  assign wr_hit  = req_i && we_i && aligned;
  assign rd_hit  = req_i && !we_i && aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      match_q <= '0;
      load_q  <= '0;
    end else if (wr_hit) begin
      case (sel)
        REG_MATCH: match_q <= wdata_i;
        REG_LOAD:  load_q  <= wdata_i;
        REG_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[3:0]);
        default: ;
      endcase
    end
  end

  assign irq_o     = raw_i && ctrl_q.ie && !ctrl_q.mask;
  assign load_wr_o = wr_hit && (sel == REG_LOAD);
  assign ack_o     = rd_hit && (sel == REG_ACK);

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      case (sel)
        REG_COUNT: rdata_o = count_i;
        REG_MATCH: rdata_o = match_q;
        REG_LOAD:  rdata_o = load_q;
        REG_CTRL:  rdata_o = {{(DW-4){1'b0}}, ctrl_q};
        REG_STAT:  rdata_o = {{(DW-1){1'b0}}, irq_o};
        REG_RAW:   rdata_o = {{(DW-1){1'b0}}, raw_i};
        REG_ID:    rdata_o = VERSION;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign match_o = match_q;
  assign load_o  = load_q;

  p_ro_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !aligned) |=> $stable(ctrl_q) && $stable(match_q) && $stable(load_q));
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
  import rtc_seconds_pkg::*;
#(
  parameter int unsigned   CLKS_PER_TICK = 32768,
  parameter logic [31:0]   VERSION       = 32'h0001_0200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] match_val, load_val, count;
  logic          load_wr, ack, raw, tick;

  rtc_reg_bank #(.VERSION(VERSION)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .count_i   (count),
    .raw_i     (raw),
    .ctrl_o    (ctrl),
    .match_o   (match_val),
    .load_o    (load_val),
    .load_wr_o (load_wr),
    .ack_o     (ack),
    .irq_o     (irq_o),
    .rdata_o   (rdata_o)
  );

  rtc_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.run),
    .tick_o (tick)
  );

  rtc_sec_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wrap_i     (ctrl.wrap),
    .load_wr_i  (load_wr),
    .load_val_i (load_val),
    .match_i    (match_val),
    .ack_i      (ack),
    .count_o    (count),
    .raw_o      (raw)
  );

  p_irq_needs_raw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw);
  p_irq_off_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mask |-> !irq_o);
endmodule

// File: tb/rtc_seconds_alarm_tb.sv
module rtc_seconds_alarm_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NT         = 4;
  localparam logic [31:0] VER        = 32'h0001_0200;
  localparam int          NV         = 9;

  localparam logic [4:0]  V_WA [NV] = '{5'h04, 5'h08, 5'h0C, 5'h00, 5'h1C, 5'h14, 5'h10, 5'h0D, 5'h05};
  localparam logic [31:0] V_WD [NV] = '{32'hA5A5_5A5A, 32'h1234_5678, 32'hFFFF_FFF2, 32'hDEAD_BEEF,
                                        32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hF, 32'h0};
  localparam logic [4:0]  V_RA [NV] = '{5'h04, 5'h08, 5'h0C, 5'h00, 5'h1C, 5'h14, 5'h10, 5'h0C, 5'h05};
  localparam logic [31:0] V_EX [NV] = '{32'hA5A5_5A5A, 32'h1234_5678, 32'h2, 32'h0,
                                        VER, 32'h0, 32'h0, 32'h2, 32'h0};
  localparam string       V_TAG[NV] = '{"R9", "R3", "R9", "R8", "R8", "R8", "R8", "R8", "R8"};

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, irq;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds_alarm #(.CLKS_PER_TICK(NT), .VERSION(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(1);
    do_reset();

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), rv);
      chk("R1 reg", rv, (i == 7) ? VER : 32'h0);
    end

    // vector table: write, then read back
    for (int i = 0; i < NV; i++) begin
      wr(V_WA[i], V_WD[i]);
      rd(V_RA[i], rv);
      chk(V_TAG[i], rv, V_EX[i]);
    end

    do_reset();

    // R3/R2: preload lands at first pulse, counting every NT cycles
    wr(5'h08, 32'd100);
    rd(5'h00, rv); chk("R3 no early load", rv, 32'd0);
    wr(5'h0C, 32'h4);
    idle(NT - 1);
    rd(5'h00, rv); chk("R3 before pulse", rv, 32'd0);
    rd(5'h00, rv); chk("R3 loaded", rv, 32'd100);
    idle(NT - 1);
    rd(5'h00, rv); chk("R2 increment", rv, 32'd101);
    wr(5'h0C, 32'h0);
    idle(3 * NT);
    rd(5'h00, rv); chk("R2 hold", rv, 32'd101);

    // R4/R5/R6 with wrap clear
    wr(5'h04, 32'd103);
    wr(5'h0C, 32'h5);
    idle(2 * NT - 1);
    rd(5'h14, rv); chk("R4 raw before match", rv, 32'h0);
    chk("R5 irq on match", {31'b0, irq}, 32'h1);
    rd(5'h10, rv); chk("R5 masked status", rv, 32'h1);
    wr(5'h0C, 32'h7);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    rd(5'h14, rv); chk("R4 raw sticky", rv, 32'h1);
    rd(5'h10, rv); chk("R5 masked status off", rv, 32'h0);
    rd(5'h18, rv);
    rd(5'h14, rv); chk("R6 ack clears", rv, 32'h0);
    rd(5'h00, rv); chk("R7 no wrap", rv, 32'd104);
    wr(5'h0C, 32'h0);

    // R7 wrap to zero after match
    wr(5'h08, 32'd200);
    wr(5'h04, 32'd202);
    wr(5'h0C, 32'hD);
    idle(4 * NT - 1);
    rd(5'h00, rv); chk("R7 at match", rv, 32'd202);
    rd(5'h00, rv); chk("R7 wrapped", rv, 32'd0);
    chk("R5 irq wrap", {31'b0, irq}, 32'h1);
    rd(5'h18, rv);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
    wr(5'h0C, 32'h0);

    // R7 natural rollover, match on zero
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h04, 32'h0);
    wr(5'h0C, 32'h5);
    idle(2 * NT - 1);
    rd(5'h00, rv); chk("R7 all ones", rv, 32'hFFFF_FFFF);
    rd(5'h00, rv); chk("R7 rollover", rv, 32'h0);
    chk("R4 match at zero", {31'b0, irq}, 32'h1);

    finish_run();
  end
endmodule